// File: doc/BRIEF.md
# Station Address ROM Reader

This block loads a 48-bit network station address from a byte-wide read-only memory in which the useful bytes sit 16 locations apart. A one-cycle start pulse begins a load. The block then walks eight ROM locations in ascending order and mirrors the bit order of each byte it gets back. It keeps the first six mirrored bytes as the address and folds all eight into an XOR checksum.

At the end of the load the block raises a one-cycle done pulse. In the same cycle it publishes either a valid address or a checksum failure. The memory port is a plain synchronous read port: the block drives an address, and the data for that address arrives a fixed, parameterised number of clock edges later. The block holds the result until the next accepted start.

Top module: `stationAddrReader`

## Requirements
- R1: After reset, loadDone, addrValid and sumFail are 0 and stationAddr is all zeros.
- R2: Each load presents exactly eight ROM addresses in ascending order. Byte j is read at romAddr = j*16, so the low four address bits are always 0. Each address is held for READ_LAT+1 cycles.
- R3: Each byte returned by the ROM is bit-mirrored before any use: ROM data bit i lands in bit 7-i.
- R4: stationAddr[47:40] holds mirrored byte 0, stationAddr[39:32] holds byte 1, and so on down to stationAddr[7:0], which holds mirrored byte 5.
- R5: When the XOR of all eight mirrored bytes equals 0xFF, the load ends with addrValid=1 and sumFail=0.
- R6: When that XOR differs from 0xFF, the load ends with sumFail=1, addrValid=0 and stationAddr all zeros.
- R7: The ROM presents data READ_LAT edges after it samples an address. loadDone and the result outputs change at the edge 8*(READ_LAT+1)+1 edges after the edge that accepted the start.
- R8: loadDone is high for exactly one cycle per load.
- R9: A start pulse that arrives while a load is in progress has no effect. The load neither restarts nor is lengthened, and no further load follows it.
- R10: The edge that accepts a start clears addrValid, sumFail and stationAddr, and they stay cleared until the load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Request to begin a load; taken only when idle |
| romAddr | output | ROM_ADDR_W | Read address to the ROM |
| romData | input | 8 | ROM read data, READ_LAT edges after the address |
| stationAddr | output | 48 | Mirrored address, first byte in the top octet |
| addrValid | output | 1 | Last load passed the checksum |
| sumFail | output | 1 | Last load failed the checksum |
| loadDone | output | 1 | One-cycle pulse when a load ends |

## Verification
A wrong byte index or a wrong stride makes the block read a filler location. The filler bytes break the checksum, so the fault appears as sumFail, or as a wrong octet in stationAddr, at the done pulse of that same load. A wait counter that is off by one either shortens or lengthens the time to done, or captures stale pipeline data. The bench catches both by measuring the done latency on every load. A stuck or wrong control state shows up as a missing, repeated or late loadDone, either within one load length or after a start pulse given mid-load.

// File: rtl/stationAddrPkg.sv
package stationAddrPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_FINISH = 2'd2
  } loadState_t;

  typedef struct packed {
    logic clear;
    logic capture;
    logic keep;
    logic finish;
  } loadStrobe_t;

endpackage

// File: rtl/addrLoadCtrl.sv
module addrLoadCtrl
  import stationAddrPkg::*;
#(
  parameter int ROM_ADDR_W   = 8,
  parameter int STRIDE_SHIFT = 4,
  parameter int NUM_BYTES    = 8,
  parameter int ADDR_BYTES   = 6,
  parameter int READ_LAT     = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output loadStrobe_t           strb,
  output logic                  loadDone
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int LAT_W = $clog2(READ_LAT + 1);

  loadState_t       state;
  logic [IDX_W-1:0] byteIdx;
  logic [LAT_W-1:0] waitCnt;
  logic             dataReady;
  logic             lastByte;

  assign dataReady = (waitCnt == LAT_W'(READ_LAT));
  assign lastByte  = (byteIdx == IDX_W'(NUM_BYTES - 1));
  assign romAddr   = ROM_ADDR_W'({byteIdx, {STRIDE_SHIFT{1'b0}}});

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:   strb.clear = startPulse;
      ST_FETCH: begin
        strb.capture = dataReady;
        strb.keep    = dataReady && ({1'b0, byteIdx} < (IDX_W + 1)'(ADDR_BYTES));
      end
      ST_FINISH: strb.finish = 1'b1;
      default:   strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      waitCnt  <= '0;
      loadDone <= 1'b0;
    end else begin
      loadDone <= strb.finish;
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state   <= ST_FETCH;
            byteIdx <= '0;
            waitCnt <= '0;
          end
        end
        ST_FETCH: begin
          if (dataReady) begin
            waitCnt <= '0;
            if (lastByte) state <= ST_FINISH;
            else          byteIdx <= byteIdx + IDX_W'(1);
          end else begin
            waitCnt <= waitCnt + LAT_W'(1);
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R8: done never lasts past one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  // R2: address is held while its data is still in flight
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && !strb.capture) |=> $stable(romAddr));

  // R9: a start during a fetch neither restarts nor advances the walk
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && startPulse && !strb.capture)
      |=> (state == ST_FETCH && $stable(byteIdx)));

  // R8: done follows only a finish step
  a_r8_done_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(state) == ST_FINISH);

endmodule

// File: rtl/addrLoadPath.sv
module addrLoadPath
  import stationAddrPkg::*;
#(
  parameter int          ADDR_BYTES  = 6,
  parameter logic [7:0]  CHECK_VALUE = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  loadStrobe_t             strb,
  input  logic [7:0]              romData,
  output logic [ADDR_BYTES*8-1:0] stationAddr,
  output logic                    addrValid,
  output logic                    sumFail
);

  localparam int ADDR_W = ADDR_BYTES * 8;

  logic [7:0]        mirByte;
  logic [7:0]        xorAcc;
  logic [ADDR_W-1:0] addrShift;

  for (genvar b = 0; b < 8; b++) begin : g_mirror
    assign mirByte[b] = romData[7 - b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xorAcc      <= '0;
      addrShift   <= '0;
      stationAddr <= '0;
      addrValid   <= 1'b0;
      sumFail     <= 1'b0;
    end else if (strb.clear) begin
      xorAcc      <= '0;
      addrShift   <= '0;
      stationAddr <= '0;
      addrValid   <= 1'b0;
      sumFail     <= 1'b0;
    end else begin
      if (strb.capture) begin
        xorAcc <= xorAcc ^ mirByte;
        if (strb.keep) addrShift <= {addrShift[ADDR_W-9:0], mirByte};
      end
      if (strb.finish) begin
        if (xorAcc == CHECK_VALUE) begin
          stationAddr <= addrShift;
          addrValid   <= 1'b1;
          sumFail     <= 1'b0;
        end else begin
          stationAddr <= '0;
          addrValid   <= 1'b0;
          sumFail     <= 1'b1;
        end
      end
    end
  end

  // R5/R6: the two verdicts never coexist
  a_r5_verdict_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && sumFail));

  // R6: a failed load shows no address
  a_r6_zero_on_fail: assert property (@(posedge clk) disable iff (!rstN)
    sumFail |-> stationAddr == '0);

  // R10: an accepted start wipes the previous verdict
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!addrValid && !sumFail && stationAddr == '0));

  // R5: each finished load yields exactly one verdict
  a_r5_verdict_given: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (addrValid != sumFail));

endmodule

// File: rtl/stationAddrReader.sv
module stationAddrReader
  import stationAddrPkg::*;
#(
  parameter int         ROM_ADDR_W   = 8,
  parameter int         STRIDE_SHIFT = 4,
  parameter int         NUM_BYTES    = 8,
  parameter int         ADDR_BYTES   = 6,
  parameter int         READ_LAT     = 1,
  parameter logic [7:0] CHECK_VALUE  = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  output logic [ROM_ADDR_W-1:0]   romAddr,
  input  logic [7:0]              romData,
  output logic [ADDR_BYTES*8-1:0] stationAddr,
  output logic                    addrValid,
  output logic                    sumFail,
  output logic                    loadDone
);

  loadStrobe_t strb;

  addrLoadCtrl #(
    .ROM_ADDR_W  (ROM_ADDR_W),
    .STRIDE_SHIFT(STRIDE_SHIFT),
    .NUM_BYTES   (NUM_BYTES),
    .ADDR_BYTES  (ADDR_BYTES),
    .READ_LAT    (READ_LAT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .romAddr   (romAddr),
    .strb      (strb),
    .loadDone  (loadDone)
  );

  addrLoadPath #(
    .ADDR_BYTES (ADDR_BYTES),
    .CHECK_VALUE(CHECK_VALUE)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .romData    (romData),
    .stationAddr(stationAddr),
    .addrValid  (addrValid),
    .sumFail    (sumFail)
  );

endmodule

// File: tb/test_stationAddrReader.sv
module test_stationAddrReader;

  localparam int LAT     = 2;
  localparam int EXP_LAT = 8 * (LAT + 1) + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  romAddr;
  logic [7:0]  romData;
  logic [47:0] stationAddr;
  logic        addrValid, sumFail, loadDone;

  logic [7:0] romMem [256];
  logic [7:0] romPipe [LAT];
  logic [7:0] logicalBytes [8];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stationAddrReader #(.READ_LAT(LAT)) i_stationAddrReader (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .romAddr(romAddr), .romData(romData),
    .stationAddr(stationAddr), .addrValid(addrValid),
    .sumFail(sumFail), .loadDone(loadDone)
  );

  always_ff @(posedge clk) begin
    romPipe[0] <= romMem[romAddr];
    for (int k = 1; k < LAT; k++) romPipe[k] <= romPipe[k-1];
  end
  assign romData = romPipe[LAT-1];

  function automatic logic [7:0] mirror8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadRom();
    for (int a = 0; a < 256; a++) romMem[a] = 8'h5A ^ 8'(a * 7);
    for (int j = 0; j < 8; j++) romMem[j*16] = mirror8(logicalBytes[j]);
  endtask

  task automatic makeGood();
    logic [7:0] x;
    x = 8'hFF;
    for (int j = 0; j < 8; j++) if (j != 6) begin
      logicalBytes[j] = 8'($urandom);
      x ^= logicalBytes[j];
    end
    logicalBytes[6] = x;
  endtask

  // midStart: cycle at which a stray start is given during the load, or -1
  task automatic runLoad(input int midStart, input string tag);
    int cycles;
    bit strideOk;
    logic [7:0] x;
    logic [47:0] expAddr;
    loadRom();
    x = 8'h00;
    for (int j = 0; j < 8; j++) x ^= logicalBytes[j];
    expAddr = {logicalBytes[0], logicalBytes[1], logicalBytes[2],
               logicalBytes[3], logicalBytes[4], logicalBytes[5]};
    @(negedge clk) startPulse = 1'b1;
    @(posedge clk); #1 startPulse = 1'b0;
    check(!addrValid && !sumFail && stationAddr == 0, {"R10 clear ", tag},
          {addrValid, sumFail}, 0);
    cycles = 0;
    strideOk = 1;
    while (!loadDone && cycles < 100) begin
      if (romAddr[3:0] != 0 || romAddr[7:4] > 7) strideOk = 0;
      @(posedge clk); #1;
      cycles++;
      startPulse = (cycles == midStart);
    end
    startPulse = 1'b0;
    check(cycles == EXP_LAT, {"R7 latency ", tag}, cycles, EXP_LAT);
    check(strideOk, {"R2 stride ", tag}, romAddr, 0);
    if (x == 8'hFF) begin
      check(addrValid && !sumFail, {"R5 verdict ", tag}, {addrValid, sumFail}, 2);
      check(stationAddr == expAddr, {"R4 R3 address ", tag}, stationAddr, expAddr);
    end else begin
      check(!addrValid && sumFail, {"R6 verdict ", tag}, {addrValid, sumFail}, 1);
      check(stationAddr == 0, {"R6 zero address ", tag}, stationAddr, 0);
    end
    @(posedge clk); #1;
    check(!loadDone, {"R8 single pulse ", tag}, loadDone, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) romMem[a] = 8'h00;
    for (int k = 0; k < LAT; k++) romPipe[k] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check(!loadDone && !addrValid && !sumFail && stationAddr == 0, "R1 reset",
          {loadDone, addrValid, sumFail}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(!loadDone && stationAddr == 0, "R1 after release", stationAddr, 0);

    // R3: asymmetric bytes make a missing or wrong mirror visible
    logicalBytes = '{8'h01, 8'h02, 8'h0F, 8'h80, 8'hC4, 8'h3B, 8'h00, 8'h10};
    begin
      logic [7:0] x;
      x = 8'hFF;
      for (int j = 0; j < 8; j++) if (j != 6) x ^= logicalBytes[j];
      logicalBytes[6] = x;
    end
    runLoad(-1, "R3 mirror pattern");

    // good loads with random content
    for (int n = 0; n < 16; n++) begin
      makeGood();
      runLoad(-1, "R5 random good");
    end

    // sweep: every single-bit corruption of every byte must fail
    for (int p = 0; p < 8; p++) begin
      for (int b = 0; b < 8; b++) begin
        makeGood();
        logicalBytes[p][b] = ~logicalBytes[p][b];
        runLoad(-1, "R6 one-bit sweep");
      end
    end

    // R9: stray starts mid-load at several points
    for (int m = 2; m < EXP_LAT; m += 5) begin
      makeGood();
      runLoad(m, "R9 mid-load start");
      begin
        bit extra;
        extra = 0;
        repeat (EXP_LAT + 5) begin
          @(posedge clk); #1;
          if (loadDone) extra = 1;
        end
        check(!extra, "R9 no second load", extra, 0);
      end
    end

    // R10: result is held after done until the next start
    makeGood();
    runLoad(-1, "R10 hold setup");
    repeat (10) @(posedge clk);
    #1;
    check(addrValid && !sumFail, "R10 held verdict", {addrValid, sumFail}, 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule